// File: doc/BRIEF.md
# Serial ID bitstream sync decoder

The block recovers a 28-nibble identification record from a serial bit stream read out of an identification PROM. After a start pulse it stores two windows of samples, one per segment, each as many bits long as the window length given with the start pulse. It then works through each stored window in turn. First it hunts bit by bit for a run of eight ones that marks the segment. Then it assembles six data bytes from the bits that follow. When the end of the window is reached it continues from the start of the same window.

Each byte, including the sync byte, is split into two nibbles that go into a 28-entry record. The record is readable at any time through an index port. Once both segments are in, a decimal checksum held in the record is compared with the sum of the other nibbles. A one-cycle done strobe then reports the outcome on an ok flag. The PROM read timing and the retrace synchronisation that decide when the samples are taken are provided by the surrounding logic.

Top module: `serial_id_sync`

## Requirements
- R1: After reset and after every start pulse, done and ok are low and all 28 record nibbles read 0. A start pulse abandons any run in progress.
- R2: After a start, the block stores exactly win_len samples (1..MAX_WIN) for segment A and then win_len samples for segment B, taking one bit per cycle in which smp_vld is high. Strobes given outside this capture phase have no effect on the record or on done.
- R3: A sync is detected when the last eight bits scanned, shifted in MSB first with the shift register cleared at the start of the segment's scan, are all ones. Segment A's sync is stored as 0xF at indices 0 and 1, and segment B's sync as 0xF at indices 14 and 15.
- R4: The scan for a segment's sync starts at window position 0 and may cover the window at most twice. A match on the final bit of the second pass still counts. If the second pass ends without a match, done pulses with ok low, and nibbles that have not yet been written stay 0.
- R5: After a sync, the next 48 bits of the same window are taken in order, wrapping from the window end back to position 0 as often as needed. They form six bytes, each stored as its high nibble and then its low nibble, at indices 2..13 for segment A and 16..27 for segment B.
- R6: The segment B scan begins only after segment A's 14 nibbles are complete. It starts from position 0 of segment B's window with a cleared shift register.
- R7: The checksum passes when the sum of nibbles 0..23 plus nibble 27, minus 60, equals 100*n24 + 10*n25 + n26.
- R8: ok is high only if both syncs were found and the checksum passed. It holds its value until the next start pulse.
- R9: Each started run that is not abandoned ends with exactly one done pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the block and begins a new capture |
| smp_vld | input | 1 | Sample strobe |
| smp_bit | input | 1 | Sampled data bit |
| win_len | input | $clog2(MAX_WIN+1) | Samples per segment window, latched at start |
| rd_idx | input | 5 | Record nibble index to read (0..27) |
| rd_nib | output | 4 | Nibble at rd_idx, 0 for indices above 27 |
| done | output | 1 | One-cycle end-of-run strobe |
| ok | output | 1 | Record found and checksum valid |

## Verification
Two of the block's functions can fall on the same cycle: the two-pass limit of the sync scan ending, and a sync match being made. A 4-bit window filled with ones provokes this. The shift register holds only four ones after the first pass, so the eighth one arrives on the very last bit the second pass may read. The coincidence is judged from the record: all 28 nibbles must read 0xF, with ok low because that record fails its checksum, rather than the run stopping after a failed search. A 7-ones window checks the case next to it, where a near miss must fail the scan.

// File: rtl/serial_id_sync.sv
module serial_id_sync #(
  parameter int MAX_WIN = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         smp_vld,
  input  logic                         smp_bit,
  input  logic [$clog2(MAX_WIN+1)-1:0] win_len,
  input  logic [4:0]                   rd_idx,
  output logic [3:0]                   rd_nib,
  output logic                         done,
  output logic                         ok
);
  localparam int PW     = $clog2(MAX_WIN);
  localparam int LW     = $clog2(MAX_WIN + 1);
  localparam int NIB    = 28;
  localparam int DBYTES = 6;
  localparam int BUFSZ  = 2 ** (PW + 1);

  typedef enum logic [2:0] {S_IDLE, S_CAP, S_HUNT, S_COLL, S_CHK} st_t;

  st_t              st;
  logic [BUFSZ-1:0] sbuf;
  logic             seg, pass;
  logic [PW-1:0]    pos, ptr;
  logic [LW-1:0]    wl;
  logic [7:0]       sh;
  logic [2:0]       bcnt, nbyte;
  logic [4:0]       widx;
  logic [3:0]       nib [32];

  wire       cur_bit = sbuf[{seg, ptr}];
  wire [7:0] sh_nxt  = {sh[6:0], cur_bit};
  wire       at_end  = (LW'(ptr) == wl - LW'(1));
  wire       pos_end = (LW'(pos) == wl - LW'(1));
  wire [PW-1:0] ptr_nxt = at_end ? '0 : ptr + PW'(1);

  assign rd_nib = (rd_idx < 5'(NIB)) ? nib[rd_idx] : 4'h0;

  logic [11:0] nsum, dec;
  always_comb begin
    nsum = 12'(nib[27]);
    for (int i = 0; i < 24; i++) nsum = nsum + 12'(nib[i]);
    dec = 12'(nib[24]) * 12'd100 + 12'(nib[25]) * 12'd10 + 12'(nib[26]);
  end
  wire ck_ok = (nsum == dec + 12'd60);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sbuf <= '0; seg <= 1'b0; pass <= 1'b0;
      pos <= '0; ptr <= '0; wl <= LW'(1); sh <= '0;
      bcnt <= '0; nbyte <= '0; widx <= '0;
      done <= 1'b0; ok <= 1'b0;
      for (int i = 0; i < 32; i++) nib[i] <= 4'h0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st <= S_CAP; seg <= 1'b0; pass <= 1'b0; pos <= '0; ptr <= '0;
        wl <= win_len; sh <= '0; bcnt <= '0; nbyte <= '0; widx <= '0;
        ok <= 1'b0;
        for (int i = 0; i < 32; i++) nib[i] <= 4'h0;
      end else begin
        case (st)
          S_CAP: if (smp_vld) begin
            sbuf[{seg, pos}] <= smp_bit;
            if (pos_end) begin
              pos <= '0;
              if (seg) begin
                st <= S_HUNT; seg <= 1'b0; ptr <= '0; pass <= 1'b0; sh <= '0;
              end else seg <= 1'b1;
            end else pos <= pos + PW'(1);
          end
          S_HUNT: begin
            sh  <= sh_nxt;
            ptr <= ptr_nxt;
            if (sh_nxt == 8'hFF) begin
              nib[widx] <= 4'hF; nib[widx + 5'd1] <= 4'hF;
              widx <= widx + 5'd2;
              bcnt <= '0; nbyte <= '0;
              st <= S_COLL;
            end else if (at_end) begin
              if (pass) begin
                st <= S_IDLE; done <= 1'b1; ok <= 1'b0;
              end else pass <= 1'b1;
            end
          end
          S_COLL: begin
            sh   <= sh_nxt;
            ptr  <= ptr_nxt;
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              nib[widx] <= sh_nxt[7:4]; nib[widx + 5'd1] <= sh_nxt[3:0];
              widx  <= widx + 5'd2;
              nbyte <= nbyte + 3'd1;
              if (nbyte == 3'(DBYTES - 1)) begin
                if (!seg) begin
                  seg <= 1'b1; st <= S_HUNT; ptr <= '0; pass <= 1'b0; sh <= '0;
                end else st <= S_CHK;
              end
            end
          end
          S_CHK: begin
            st <= S_IDLE; done <= 1'b1; ok <= ck_ok;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !ok));
  a_r8_ok_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (done || $stable(ok)));
  a_r8_ok_rises_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> done);
  a_r4_ptr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HUNT || st == S_COLL) |-> (LW'(ptr) < wl));
  a_r5_store_bound: assert property (@(posedge clk) disable iff (!rst_n)
    widx <= 5'(NIB));
endmodule

// File: tb/sim_serial_id_sync.sv
module sim_serial_id_sync;
  localparam int MW = 64;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, smp_vld = 1'b0, smp_bit = 1'b0;
  logic [6:0] win_len = 7'd1;
  logic [4:0] rd_idx = 5'd0;
  logic [3:0] rd_nib;
  logic done, ok;

  serial_id_sync #(.MAX_WIN(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_vld(smp_vld), .smp_bit(smp_bit),
    .win_len(win_len), .rd_idx(rd_idx), .rd_nib(rd_nib), .done(done), .ok(ok));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  int exp_nib [28];
  int rec [28];

  task automatic chk(input bit cond, input string req, input int act, input int expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_seg(input logic [63:0] w, input int W, input int base, output bit fnd);
    logic [7:0] s = 8'h00;
    logic [7:0] v;
    int p = 0;
    fnd = 0;
    for (int k = 0; k < 2 * W; k++) begin
      s = {s[6:0], w[k % W]};
      if (s == 8'hFF) begin fnd = 1; p = (k + 1) % W; break; end
    end
    if (fnd) begin
      exp_nib[base] = 15; exp_nib[base + 1] = 15;
      for (int b = 0; b < 6; b++) begin
        for (int j = 0; j < 8; j++) begin v = {v[6:0], w[p]}; p = (p + 1) % W; end
        exp_nib[base + 2 + 2 * b] = int'(v[7:4]);
        exp_nib[base + 3 + 2 * b] = int'(v[3:0]);
      end
    end
  endtask

  task automatic make_rec(input bit bad);
    int s = 0;
    for (int i = 0; i < 28; i++) rec[i] = int'($urandom_range(0, 9));
    rec[0] = 15; rec[1] = 15; rec[14] = 15; rec[15] = 15;
    for (int i = 2; i < 24; i++) if (i != 14 && i != 15) s += rec[i];
    s += rec[27];
    rec[24] = s / 100; rec[25] = (s / 10) % 10; rec[26] = s % 10;
    if (bad) rec[26] = (rec[26] + 1) % 10;
  endtask

  function automatic logic [63:0] place(input int base, input int off, input int W);
    logic [63:0] w = '0;
    for (int j = 0; j < 7; j++)
      for (int b = 0; b < 8; b++) begin
        logic [7:0] byt = {4'(rec[base + 2 * j]), 4'(rec[base + 2 * j + 1])};
        w[(off + 8 * j + b) % W] = byt[7 - b];
      end
    return w;
  endfunction

  task automatic feed(input logic [63:0] w, input int W);
    for (int i = 0; i < W; i++) begin
      smp_vld = 1'b1; smp_bit = w[i];
      @(negedge clk);
      if (i % 5 == 4) begin smp_vld = 1'b0; @(negedge clk); end
    end
    smp_vld = 1'b0;
  endtask

  task automatic pulse_start(input int W);
    start = 1'b1; win_len = 7'(W);
    @(negedge clk);
    start = 1'b0;
    chk(!done && !ok, "R1 start clears flags", int'(done), 0);
  endtask

  task automatic run_case(input logic [63:0] w0, input logic [63:0] w1, input int W,
                          input bit abort_first, input string tag);
    bit f0, f1, seen, exp_ok, nib_ok, extra;
    int s = 0, bad_i = 0, bad_v = 0;
    for (int i = 0; i < 28; i++) exp_nib[i] = 0;
    f1 = 0;
    model_seg(w0, W, 0, f0);
    if (f0) model_seg(w1, W, 14, f1);
    for (int i = 0; i < 24; i++) s += exp_nib[i];
    s += exp_nib[27];
    exp_ok = f0 && f1 && (s - 60 == 100 * exp_nib[24] + 10 * exp_nib[25] + exp_nib[26]);
    @(negedge clk);
    if (abort_first) begin
      pulse_start(W);
      feed(~w0, W);
    end
    pulse_start(W);
    rd_idx = 5'd0; #1;
    chk(rd_nib == 4'h0, "R1 store cleared by start", int'(rd_nib), 0);
    @(negedge clk);
    feed(w0, W);
    feed(w1, W);
    seen = 0;
    for (int t = 0; t < 3000; t++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, {"R9 done pulse ", tag}, int'(seen), 1);
    chk(ok == exp_ok, {"R8 ok flag ", tag}, int'(ok), int'(exp_ok));
    @(negedge clk);
    chk(!done, {"R9 done one cycle ", tag}, int'(done), 0);
    nib_ok = 1;
    for (int i = 0; i < 28; i++) begin
      rd_idx = 5'(i); #1;
      if (int'(rd_nib) != exp_nib[i] && nib_ok) begin nib_ok = 0; bad_i = i; bad_v = int'(rd_nib); end
    end
    chk(nib_ok, {"R5 record nibbles ", tag}, bad_v, exp_nib[bad_i]);
    extra = 0;
    for (int i = 0; i < 6; i++) begin
      smp_vld = 1'b1; smp_bit = 1'b1;
      @(negedge clk);
      if (done) extra = 1;
    end
    smp_vld = 1'b0;
    rd_idx = 5'd27; #1;
    chk(!extra && int'(rd_nib) == exp_nib[27] && ok == exp_ok,
        {"R2 late strobes ignored ", tag}, int'(rd_nib), exp_nib[27]);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin smp_vld = 1'b1; smp_bit = 1'b1; @(negedge clk); end
    smp_vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !ok, "R1 reset flags", int'(ok), 0);
    for (int i = 0; i < 32; i++) begin
      rd_idx = 5'(i); #1;
      chk(rd_nib == 4'h0, "R1 reset record zero", int'(rd_nib), 0);
    end
    for (int off = 0; off < 60; off++) begin
      make_rec(0);
      run_case(place(0, off, 60), place(14, (off * 7 + 3) % 60, 60), 60, 0, "R3 R6 R7 sweep W60");
    end
    for (int off = 56; off < 64; off++) begin
      make_rec(0);
      run_case(place(0, off, 64), place(14, 63 - off, 64), 64, 0, "R3 wrap W64");
    end
    make_rec(1);
    run_case(place(0, 5, 58), place(14, 9, 58), 58, 0, "R7 bad checksum");
    make_rec(0);
    run_case(64'h0, place(14, 0, 60), 60, 0, "R4 no sync segment A");
    run_case(place(0, 2, 60), 64'h0, 60, 0, "R4 no sync segment B");
    run_case(64'hF, 64'hF, 4, 0, "R4 match on last bit of second pass");
    run_case(64'h7F, 64'h7F, 7, 0, "R4 R5 W7 all ones");
    run_case(64'h7F, 64'h7F, 8, 0, "R4 near miss seven ones");
    run_case(64'h1, 64'h1, 1, 0, "R4 single bit window");
    make_rec(0);
    run_case(place(0, 11, 62), place(14, 40, 62), 62, 1, "R1 abandoned run");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule